// File: doc/BRIEF.md
# Halfword Pack Execution Unit

This unit builds a 32-bit result from two source operands. The result takes one half from the first operand and the other half from a shifted copy of the second operand. A one-bit mode input selects between two combinations:

- **Bottom-top mode** keeps the low half of operand A. The high half comes from operand B after a logical left shift.
- **Top-bottom mode** keeps the high half of operand A. The low half comes from operand B after an arithmetic right shift.

In top-bottom mode a shift field of zero means a 32-bit shift, not "no shift". In bottom-top mode a zero field leaves operand B unshifted.

The unit also decides whether the result may be written back. A 4-bit condition code is tested against the current N, Z, C and V flags. The flags are only read, never produced. The destination register index is checked too: index 13 (stack pointer) and index 15 (program counter) are refused. Result, write-enable, destination index and the illegal-destination flag are registered. They appear one clock after an input strobe.

Top module: `hpack_unit`

## Requirements
- R1: In bottom-top mode (`pk_mode`=0), `res_q[15:0]` equals `src_a[15:0]`.
- R2: In bottom-top mode, `res_q[31:16]` equals bits 31:16 of `src_b` shifted left logically by `shamt` (0 to 31). A value of 0 leaves `src_b` unshifted.
- R3: In top-bottom mode (`pk_mode`=1), `res_q[31:16]` equals `src_a[31:16]`.
- R4: In top-bottom mode with `shamt` from 1 to 31, `res_q[15:0]` equals bits 15:0 of `src_b` shifted right arithmetically by `shamt`.
- R5: In top-bottom mode with `shamt`=0, the shift is 32 positions. Every bit of `res_q[15:0]` then equals `src_b[31]`.
- R6: The condition code `cc` is tested against `flags` = {N,Z,C,V}, bit 3 = N and bit 0 = V. The encodings are:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C & !Z
  - 9: !C | Z
  - 10: N==V
  - 11: N!=V
  - 12: !Z & N==V
  - 13: Z | N!=V
  - 14 and 15: always

  `wr_en_q` is 1 only when the condition passes and the destination is legal.
- R7: When the destination `rd_idx` is 13 or 15, `bad_rd_q` is 1 and `wr_en_q` is 0, whatever the condition result.
- R8: Outputs update one clock after `in_vld`. `out_vld_q` follows `in_vld` with one cycle of delay. In a cycle without a strobe, `out_vld_q`, `wr_en_q` and `bad_rd_q` are 0, while `res_q` and `rd_q` keep their last values.
- R9: Synchronous active-high `rst` clears every output to 0.
- R10: `res_q` and `rd_q` do not depend on `cc` or `flags`. They are loaded even when the condition fails or the destination is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input strobe |
| src_a | input | 32 | First operand (kept half) |
| src_b | input | 32 | Second operand (shifted) |
| shamt | input | 5 | Shift amount field |
| pk_mode | input | 1 | 0 = bottom-top, 1 = top-bottom |
| cc | input | 4 | Condition code |
| flags | input | 4 | Current flags {N,Z,C,V} |
| rd_idx | input | 4 | Destination register index |
| out_vld_q | output | 1 | Registered strobe |
| res_q | output | 32 | Registered packed result |
| wr_en_q | output | 1 | Registered write-enable |
| rd_q | output | 4 | Registered destination index |
| bad_rd_q | output | 1 | Registered illegal-destination flag |

## Verification
The hardest situation to reach is a combination of three things: top-bottom mode, a zero shift field, and a negative second operand. Random stimulus alone rarely lands on all three at once, and only that case separates a 32-bit shift from no shift. The stimulus therefore weights the shift field toward 0, 1, 15, 16 and 31, draws operand signs evenly, and adds directed vectors for both signs at a zero shift. An illegal destination paired with a passing condition is the other case that matters. To reach it, every condition code is swept against all sixteen flag patterns, with legal and illegal destinations mixed in.

// File: rtl/hpack_pkg.sv
package hpack_pkg;

  typedef enum logic {
    PACK_BT = 1'b0,
    PACK_TB = 1'b1
  } pack_mode_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Condition test: flags are only read here.
  function automatic logic cond_holds(input cond_e code, input flags_t f);
    logic r;
    case (code)
      CC_EQ:   r = f.z;
      CC_NE:   r = !f.z;
      CC_CS:   r = f.c;
      CC_CC:   r = !f.c;
      CC_MI:   r = f.n;
      CC_PL:   r = !f.n;
      CC_VS:   r = f.v;
      CC_VC:   r = !f.v;
      CC_HI:   r = f.c && !f.z;
      CC_LS:   r = !f.c || f.z;
      CC_GE:   r = (f.n == f.v);
      CC_LT:   r = (f.n != f.v);
      CC_GT:   r = !f.z && (f.n == f.v);
      CC_LE:   r = f.z || (f.n != f.v);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hpack_cond_eval.sv
module hpack_cond_eval
  import hpack_pkg::*;
(
  input  logic [3:0] cc,
  input  logic [3:0] flags,
  output logic       pass
);
  always_comb begin
    pass = cond_holds(cond_e'(cc), flags_t'(flags));
  end
endmodule

// File: rtl/hpack_dest_check.sv
module hpack_dest_check #(
  parameter int IDX_W  = 4,
  parameter int SP_IDX = 13,
  parameter int PC_IDX = 15
) (
  input  logic [IDX_W-1:0] idx,
  output logic             illegal
);
  localparam logic [IDX_W-1:0] SP_V = IDX_W'(SP_IDX);
  localparam logic [IDX_W-1:0] PC_V = IDX_W'(PC_IDX);

  always_comb begin
    illegal = (idx == SP_V) || (idx == PC_V);
  end
endmodule

// File: rtl/hpack_shifter.sv
module hpack_shifter
  import hpack_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int HALF  = DATA_W / 2
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SH_W-1:0]   sh,
  input  logic              mode,
  output logic [DATA_W-1:0] packed_res
);
  // Left shift for bottom-top mode; a zero field means unshifted.
  function automatic logic [DATA_W-1:0] shl(input logic [DATA_W-1:0] v,
                                            input logic [SH_W-1:0] s);
    return v << s;
  endfunction

  // Arithmetic right shift for top-bottom mode; a zero field means a full-width shift.
  function automatic logic [DATA_W-1:0] sar(input logic [DATA_W-1:0] v,
                                            input logic [SH_W-1:0] s);
    logic [DATA_W-1:0] r;
    if (s == '0) r = {DATA_W{v[DATA_W-1]}};
    else         r = DATA_W'($signed(v) >>> s);
    return r;
  endfunction

  logic [DATA_W-1:0] left_w;
  logic [DATA_W-1:0] right_w;

  always_comb begin
    left_w  = shl(b, sh);
    right_w = sar(b, sh);
    if (pack_mode_e'(mode) == PACK_BT)
      packed_res = {left_w[DATA_W-1:HALF], a[HALF-1:0]};
    else
      packed_res = {a[DATA_W-1:HALF], right_w[HALF-1:0]};
  end
endmodule

// File: rtl/hpack_unit.sv
module hpack_unit #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int SP_IDX = 13,
  parameter int PC_IDX = 15,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int HALF  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [SH_W-1:0]   shamt,
  input  logic              pk_mode,
  input  logic [3:0]        cc,
  input  logic [3:0]        flags,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              out_vld_q,
  output logic [DATA_W-1:0] res_q,
  output logic              wr_en_q,
  output logic [IDX_W-1:0]  rd_q,
  output logic              bad_rd_q
);
  // Internal events named for the assertions.
  logic              cond_pass_w;
  logic              illegal_w;
  logic [DATA_W-1:0] packed_w;
  logic              commit_w;

  hpack_cond_eval u_cond (
    .cc    (cc),
    .flags (flags),
    .pass  (cond_pass_w)
  );

  hpack_dest_check #(
    .IDX_W  (IDX_W),
    .SP_IDX (SP_IDX),
    .PC_IDX (PC_IDX)
  ) u_dest (
    .idx     (rd_idx),
    .illegal (illegal_w)
  );

  hpack_shifter #(
    .DATA_W (DATA_W)
  ) u_shift (
    .a          (src_a),
    .b          (src_b),
    .sh         (shamt),
    .mode       (pk_mode),
    .packed_res (packed_w)
  );

  assign commit_w = in_vld && cond_pass_w && !illegal_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld_q <= 1'b0;
      res_q     <= '0;
      wr_en_q   <= 1'b0;
      rd_q      <= '0;
      bad_rd_q  <= 1'b0;
    end else begin
      out_vld_q <= in_vld;
      wr_en_q   <= commit_w;
      bad_rd_q  <= in_vld && illegal_w;
      if (in_vld) begin
        res_q <= packed_w;
        rd_q  <= rd_idx;
      end
    end
  end

  assert_bt_low_R1: assert property (@(posedge clk) disable iff (rst)
    in_vld && !pk_mode |=> res_q[HALF-1:0] == $past(src_a[HALF-1:0]));

  assert_tb_high_R3: assert property (@(posedge clk) disable iff (rst)
    in_vld && pk_mode |=> res_q[DATA_W-1:HALF] == $past(src_a[DATA_W-1:HALF]));

  assert_tb_full_shift_R5: assert property (@(posedge clk) disable iff (rst)
    in_vld && pk_mode && shamt == '0
      |=> res_q[HALF-1:0] == {HALF{$past(src_b[DATA_W-1])}});

  assert_no_write_bad_dest_R7: assert property (@(posedge clk) disable iff (rst)
    bad_rd_q |-> !wr_en_q);

  assert_always_code_R6: assert property (@(posedge clk) disable iff (rst)
    in_vld && cc == 4'd14 && !illegal_w |=> wr_en_q);

  assert_strobe_latency_R8: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld_q);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld_q && !wr_en_q && !bad_rd_q && $stable(res_q));

  assert_dest_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> rd_q == $past(rd_idx));

endmodule

// File: tb/hpack_unit_tb.sv
module hpack_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [4:0]  shamt = '0;
  logic        pk_mode = 1'b0;
  logic [3:0]  cc = '0;
  logic [3:0]  flags = '0;
  logic [3:0]  rd_idx = '0;
  logic        out_vld_q;
  logic [31:0] res_q;
  logic        wr_en_q;
  logic [3:0]  rd_q;
  logic        bad_rd_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hpack_unit u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .src_a(src_a), .src_b(src_b),
    .shamt(shamt), .pk_mode(pk_mode), .cc(cc), .flags(flags), .rd_idx(rd_idx),
    .out_vld_q(out_vld_q), .res_q(res_q), .wr_en_q(wr_en_q), .rd_q(rd_q),
    .bad_rd_q(bad_rd_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference: left shift via multiplication by a power of two.
  function automatic logic [15:0] ref_hi_bt(input logic [31:0] b, input logic [4:0] s);
    logic [63:0] p;
    p = {32'd0, b} * (64'd1 << s);
    return p[31:16];
  endfunction

  // Reference: arithmetic right shift one bit at a time, zero field = 32 steps.
  function automatic logic [15:0] ref_lo_tb(input logic [31:0] b, input logic [4:0] s);
    logic [31:0] r;
    int steps;
    r = b;
    steps = (s == 5'd0) ? 32 : int'(s);
    for (int i = 0; i < steps; i++) r = {r[31], r[31:1]};
    return r[15:0];
  endfunction

  function automatic logic ref_cond(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v, base;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = cy & ~z;
      3'd5: base = ~(n ^ v);
      3'd6: base = ~z & ~(n ^ v);
      default: base = 1'b1;
    endcase
    if (c[3:1] == 3'd7) return 1'b1;
    return c[0] ? ~base : base;
  endfunction

  // Apply one strobe and check the registered outputs one clock later.
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [4:0] s,
                       input logic m, input logic [3:0] c, input logic [3:0] f,
                       input logic [3:0] d);
    logic ill, pass;
    @(negedge clk);
    src_a = a; src_b = b; shamt = s; pk_mode = m; cc = c; flags = f; rd_idx = d;
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    ill  = (d == 4'd13) || (d == 4'd15);
    pass = ref_cond(c, f);
    chk("R8 out_vld", {31'd0, out_vld_q}, 32'd1);
    if (!m) begin
      chk("R1 low half", {16'd0, res_q[15:0]}, {16'd0, a[15:0]});
      chk("R2 high half", {16'd0, res_q[31:16]}, {16'd0, ref_hi_bt(b, s)});
    end else begin
      chk("R3 high half", {16'd0, res_q[31:16]}, {16'd0, a[31:16]});
      if (s == 5'd0) chk("R5 low half", {16'd0, res_q[15:0]}, {16'd0, ref_lo_tb(b, s)});
      else           chk("R4 low half", {16'd0, res_q[15:0]}, {16'd0, ref_lo_tb(b, s)});
    end
    chk("R10 rd", {28'd0, rd_q}, {28'd0, d});
    chk("R7 bad_rd", {31'd0, bad_rd_q}, {31'd0, ill});
    if (ill) chk("R7 wr_en", {31'd0, wr_en_q}, 32'd0);
    else     chk("R6 wr_en", {31'd0, wr_en_q}, {31'd0, pass});
  endtask

  task automatic idle_check();
    logic [31:0] held_r;
    logic [3:0]  held_d;
    held_r = res_q; held_d = rd_q;
    @(negedge clk);
    src_a = 32'hFFFF_FFFF; src_b = 32'h8000_0000; rd_idx = 4'd13;
    @(negedge clk);
    chk("R8 idle out_vld", {31'd0, out_vld_q}, 32'd0);
    chk("R8 idle wr_en", {31'd0, wr_en_q}, 32'd0);
    chk("R8 idle bad_rd", {31'd0, bad_rd_q}, 32'd0);
    chk("R8 idle res held", res_q, held_r);
    chk("R8 idle rd held", {28'd0, rd_q}, {28'd0, held_d});
  endtask

  function automatic logic [4:0] pick_shift();
    int k;
    k = $urandom_range(0, 9);
    case (k)
      0: return 5'd0;
      1: return 5'd1;
      2: return 5'd15;
      3: return 5'd16;
      4: return 5'd31;
      default: return 5'($urandom_range(0, 31));
    endcase
  endfunction

  initial begin
    process::self().srandom(32'd7);
    repeat (3) @(negedge clk);
    chk("R9 reset out_vld", {31'd0, out_vld_q}, 32'd0);
    chk("R9 reset res", res_q, 32'd0);
    chk("R9 reset wr_en", {31'd0, wr_en_q}, 32'd0);
    chk("R9 reset rd", {28'd0, rd_q}, 32'd0);
    chk("R9 reset bad_rd", {31'd0, bad_rd_q}, 32'd0);
    rst = 1'b0;

    // Directed shift corners, both signs, both modes.
    apply(32'h1234_5678, 32'h8000_0001, 5'd0,  1'b1, 4'd14, 4'h0, 4'd2);
    apply(32'h1234_5678, 32'h7FFF_FFFF, 5'd0,  1'b1, 4'd14, 4'h0, 4'd2);
    apply(32'h1234_5678, 32'hF00F_1234, 5'd16, 1'b1, 4'd14, 4'h0, 4'd3);
    apply(32'h1234_5678, 32'h8765_4321, 5'd31, 1'b1, 4'd14, 4'h0, 4'd4);
    apply(32'hAAAA_5555, 32'h0000_ABCD, 5'd0,  1'b0, 4'd14, 4'h0, 4'd5);
    apply(32'hAAAA_5555, 32'h0000_ABCD, 5'd16, 1'b0, 4'd14, 4'h0, 4'd5);
    apply(32'hAAAA_5555, 32'h0000_0001, 5'd31, 1'b0, 4'd14, 4'h0, 4'd6);
    apply(32'hAAAA_5555, 32'h0001_8001, 5'd15, 1'b0, 4'd14, 4'h0, 4'd7);
    // R7: illegal destinations with a passing condition.
    apply(32'h0, 32'h0, 5'd1, 1'b0, 4'd14, 4'h0, 4'd13);
    apply(32'h0, 32'h0, 5'd1, 1'b1, 4'd14, 4'h0, 4'd15);
    // R10: failing condition still loads the result.
    apply(32'hCAFE_BEEF, 32'h1357_9BDF, 5'd4, 1'b0, 4'd0, 4'h0, 4'd1);
    idle_check();

    // R6: every condition code against every flag pattern.
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        apply($urandom, $urandom, pick_shift(), 1'($urandom_range(0, 1)),
              4'(c), 4'(f), ((c + f) % 5 == 0) ? 4'd13 : 4'(f % 13));

    // Constrained random.
    for (int i = 0; i < 3000; i++) begin
      apply($urandom, $urandom, pick_shift(), 1'($urandom_range(0, 1)),
            4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
            4'($urandom_range(0, 15)));
      if (i % 500 == 0) idle_check();
    end

    // R9: reset mid-run clears outputs.
    @(negedge clk);
    src_a = 32'hFFFF_FFFF; in_vld = 1'b1; rd_idx = 4'd13;
    @(negedge clk);
    in_vld = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R9 mid reset res", res_q, 32'd0);
    chk("R9 mid reset bad_rd", {31'd0, bad_rd_q}, 32'd0);
    chk("R9 mid reset out_vld", {31'd0, out_vld_q}, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule